// File: doc/BRIEF.md
# Core Register Transfer Controller

This block is the debugger's path into the processor's register file while the core is stopped. A debugger on a simple register bus loads a 32-bit data holding register, then writes a selector word naming one core register and a direction. That single selector write launches exactly one transfer over a request/acknowledge port to the core's register file. A read transfer copies the named core register into the holding register. A write transfer copies the holding register into the named core register.

A ready bit, visible on the bus, drops when a transfer starts and rises again once it has finished. Index values that name no core register still complete normally, but they never reach the core port. One index names a packed special word, and only three bit positions of that word carry meaning. Bus writes that arrive at the wrong time are dropped, so a transfer in flight cannot be disturbed.

Top module: `regxfer_ctrl`

## Requirements
- R1: After reset `xfer_ready` is 0, `rf_req` is 0 and the holding register reads as zero.
- R2: A bus write to address 0 while `core_halted` is 1 and no transfer is active starts a transfer. The index is taken from data bits [4:0] and the direction from bit 16 (1 moves data into the core, 0 moves data out of it). In the next cycle `rf_req` is 1, `rf_idx` holds the index, `rf_we` holds the direction bit and `xfer_ready` is 0.
- R3: `rf_req`, `rf_idx` and `rf_we` hold steady until `rf_ack` is sampled high, so the request is high for (acknowledge latency + 1) cycles, and `xfer_ready` stays 0 throughout.
- R4: In the cycle after the clock edge that samples `rf_ack` high, `xfer_ready` is 1 and `rf_req` is 0. For a read, the holding register then contains `rf_rdata`.
- R5: For a write transfer, `rf_wdata` carries the holding register value and the holding register is left unchanged.
- R6: Index 20 is the packed special word, in which only data bits 25, 24 and 0 are meaningful. A read of it keeps only those bits and clears all others. A write of it drives only those bits on `rf_wdata`.
- R7: Indices 19 and 21 to 31 are reserved. A transfer to one of them never raises `rf_req`, and `xfer_ready` rises one cycle after the selector write. A read loads zero; a write leaves the holding register unchanged.
- R8: A selector write while `core_halted` is 0 is ignored. No request is made and `xfer_ready` keeps its value.
- R9: A selector write while a transfer is active is ignored. It neither changes the active transfer nor starts another one.
- R10: A bus write to address 1 loads the holding register when no transfer is active. During a transfer such a write is ignored.
- R11: Bus reads are combinational. Address 1 returns the holding register. Address 2 returns `xfer_ready` in bit 0 with zeros above it. Addresses 0 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Bus word address (0 selector, 1 holding data, 2 status) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data for `bus_addr` |
| core_halted | input | 1 | Core is stopped in debug state |
| rf_req | output | 1 | Register-file transfer request |
| rf_we | output | 1 | Transfer direction, 1 writes into the core |
| rf_idx | output | 5 | Core register index |
| rf_wdata | output | 32 | Data written into the core |
| rf_rdata | input | 32 | Data read from the core |
| rf_ack | input | 1 | Register file has completed the request |
| xfer_ready | output | 1 | Last transfer has completed |

## Verification
A wrong state in the sequencer becomes visible within one cycle, as either a request that should not be present or a ready bit with the wrong value. The bench's model compares both on every clock. A wrong latched index or direction shows up on `rf_idx` and `rf_we` as soon as the request is raised. A corrupted holding register is only exposed when the bus reads address 1 or when a write transfer drives `rf_wdata`, so the bench reads the holding register back after every transfer. Masking and reserved-index faults show up in that read-back, in the bench's copy of the core registers, and in a request counter that must stay at zero.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_BUSY = 1'b1
   } xfer_state_e;

   typedef struct packed {
      logic rsvd;
      logic special;
   } idx_class_t;

   localparam int unsigned BA_SEL  = 0;
   localparam int unsigned BA_DATA = 1;
   localparam int unsigned BA_STAT = 2;

endpackage

// File: rtl/regxfer_idx_decode.sv
module regxfer_idx_decode
   import regxfer_pkg::*;
#(
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned LAST_DIRECT = 18,
   parameter int unsigned SPECIAL_IDX = 20
) (
   input  logic [IDX_W-1:0] idx,
   output idx_class_t       cls
);
   localparam int unsigned NUM_IDX = 1 << IDX_W;

   generate
      if (LAST_DIRECT >= NUM_IDX || SPECIAL_IDX >= NUM_IDX || SPECIAL_IDX <= LAST_DIRECT) begin : g_bad_map
         $error("regxfer_idx_decode: index map does not fit IDX_W");
      end
   endgenerate

   logic [NUM_IDX-1:0] valid_map;
   logic [NUM_IDX-1:0] special_map;

   for (genvar g = 0; g < NUM_IDX; g++) begin : g_map
      assign valid_map[g]   = (g <= LAST_DIRECT) || (g == SPECIAL_IDX);
      assign special_map[g] = (g == SPECIAL_IDX);
   end

   assign cls.rsvd    = ~valid_map[idx];
   assign cls.special = special_map[idx];

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
   import regxfer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sel_wr,
   input  logic halted,
   input  logic rsvd,
   input  logic rf_ack,
   output logic busy,
   output logic ready,
   output logic start,
   output logic done,
   output logic rf_req
);
   xfer_state_e state_q;
   logic        ready_q;

   assign busy   = (state_q == XS_BUSY);
   assign start  = sel_wr & halted & ~busy;
   assign done   = busy & (rsvd | rf_ack);
   assign rf_req = busy & ~rsvd;
   assign ready  = ready_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= XS_IDLE;
         ready_q <= 1'b0;
      end else if (start) begin
         state_q <= XS_BUSY;
         ready_q <= 1'b0;
      end else if (done) begin
         state_q <= XS_IDLE;
         ready_q <= 1'b1;
      end
   end

   a_r2_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !ready));
   a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_ack) |=> rf_req);
   a_r3_no_ready_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      rf_req |-> !ready);
   a_r4_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && rf_ack) |=> (ready && !rf_req));
   a_r7_rsvd_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rsvd) |=> (!busy && ready));

endmodule

// File: rtl/regxfer_datapath.sv
module regxfer_datapath #(
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned CTRL_LSB        = 24,
   parameter int unsigned CTRL_W          = 2,
   parameter int unsigned MASK_BIT        = 0,
   parameter bit          SPECIAL_MASK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              done,
   input  logic              xfer_we,
   input  logic              rsvd,
   input  logic              special,
   input  logic [DATA_W-1:0] rf_rdata,
   output logic [DATA_W-1:0] data_q,
   output logic [DATA_W-1:0] rf_wdata
);
   generate
      if (CTRL_LSB + CTRL_W > DATA_W || MASK_BIT >= DATA_W || CTRL_W == 0) begin : g_bad_fields
         $error("regxfer_datapath: special-word fields exceed DATA_W");
      end
   endgenerate

   localparam logic [DATA_W-1:0] CTRL_FIELD =
      {{(DATA_W-CTRL_W){1'b0}}, {CTRL_W{1'b1}}} << CTRL_LSB;
   localparam logic [DATA_W-1:0] MASK_FIELD =
      {{(DATA_W-1){1'b0}}, 1'b1} << MASK_BIT;
   localparam logic [DATA_W-1:0] SPEC_MASK = CTRL_FIELD | MASK_FIELD;

   logic [DATA_W-1:0] rd_shaped;
   logic [DATA_W-1:0] wr_shaped;

   generate
      if (SPECIAL_MASK_EN) begin : g_masked
         assign rd_shaped = special ? (rf_rdata & SPEC_MASK) : rf_rdata;
         assign wr_shaped = special ? (data_q & SPEC_MASK) : data_q;
      end else begin : g_plain
         assign rd_shaped = rf_rdata;
         assign wr_shaped = data_q;
      end
   endgenerate

   assign rf_wdata = wr_shaped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (done && !xfer_we) begin
         data_q <= rsvd ? '0 : rd_shaped;
      end else if (data_wr && !busy) begin
         data_q <= wdata;
      end
   end

   a_r10_hold_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(data_q));
   a_r5_write_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      (done && xfer_we) |=> $stable(data_q));

endmodule

// File: rtl/regxfer_ctrl.sv
module regxfer_ctrl
   import regxfer_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned IDX_W       = 5,
   parameter int unsigned DIR_BIT     = 16,
   parameter int unsigned LAST_DIRECT = 18,
   parameter int unsigned SPECIAL_IDX = 20,
   parameter int unsigned CTRL_LSB    = 24,
   parameter int unsigned CTRL_W      = 2,
   parameter int unsigned MASK_BIT    = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              core_halted,
   output logic              rf_req,
   output logic              rf_we,
   output logic [IDX_W-1:0]  rf_idx,
   output logic [DATA_W-1:0] rf_wdata,
   input  logic [DATA_W-1:0] rf_rdata,
   input  logic              rf_ack,
   output logic              xfer_ready
);
   generate
      if (DIR_BIT >= DATA_W || DIR_BIT < IDX_W || ADDR_W < 2) begin : g_bad_sel
         $error("regxfer_ctrl: selector layout does not fit the bus");
      end
   endgenerate

   localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(BA_SEL);
   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BA_DATA);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BA_STAT);

   logic             sel_wr, data_wr;
   logic             busy, start, done;
   logic [IDX_W-1:0] idx_q;
   logic             we_q;
   idx_class_t       cls;
   logic [DATA_W-1:0] data_q;

   assign sel_wr  = bus_wr && (bus_addr == A_SEL);
   assign data_wr = bus_wr && (bus_addr == A_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         we_q  <= 1'b0;
      end else if (start) begin
         idx_q <= bus_wdata[IDX_W-1:0];
         we_q  <= bus_wdata[DIR_BIT];
      end
   end

   regxfer_idx_decode #(
      .IDX_W      (IDX_W),
      .LAST_DIRECT(LAST_DIRECT),
      .SPECIAL_IDX(SPECIAL_IDX)
   ) i_decode (
      .idx(idx_q),
      .cls(cls)
   );

   regxfer_seq i_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_wr(sel_wr),
      .halted(core_halted),
      .rsvd  (cls.rsvd),
      .rf_ack(rf_ack),
      .busy  (busy),
      .ready (xfer_ready),
      .start (start),
      .done  (done),
      .rf_req(rf_req)
   );

   regxfer_datapath #(
      .DATA_W  (DATA_W),
      .CTRL_LSB(CTRL_LSB),
      .CTRL_W  (CTRL_W),
      .MASK_BIT(MASK_BIT)
   ) i_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_wr (data_wr),
      .wdata   (bus_wdata),
      .busy    (busy),
      .done    (done),
      .xfer_we (we_q),
      .rsvd    (cls.rsvd),
      .special (cls.special),
      .rf_rdata(rf_rdata),
      .data_q  (data_q),
      .rf_wdata(rf_wdata)
   );

   assign rf_idx = idx_q;
   assign rf_we  = we_q;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_DATA) begin
         bus_rdata = data_q;
      end else if (bus_addr == A_STAT) begin
         bus_rdata[0] = xfer_ready;
      end
   end

   a_r3_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_req && !rf_ack) |=> ($stable(rf_idx) && $stable(rf_we)));
   a_r7_no_req_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      rf_req |-> !cls.rsvd);
   a_r8_not_halted_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && !core_halted && !busy) |=> ($stable(xfer_ready) && !rf_req));
   a_r9_busy_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && busy && !done) |=> (busy && $stable(idx_q)));

endmodule

// File: tb/test_regxfer_ctrl.sv
module test_regxfer_ctrl;
   localparam int CLK_P = 10;
   localparam logic [31:0] SPEC_M = 32'h0300_0001;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_wr;
   logic [1:0]  bus_addr;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata;
   logic        core_halted;
   logic        rf_req, rf_we, rf_ack;
   logic [4:0]  rf_idx;
   logic [31:0] rf_wdata, rf_rdata;
   logic        xfer_ready;

   always #(CLK_P/2) clk = ~clk;

   regxfer_ctrl i_regxfer_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_halted(core_halted),
      .rf_req(rf_req), .rf_we(rf_we), .rf_idx(rf_idx), .rf_wdata(rf_wdata),
      .rf_rdata(rf_rdata), .rf_ack(rf_ack), .xfer_ready(xfer_ready)
   );

   int    vectors = 0;
   int    fails   = 0;
   string cur_req = "R1";

   // core register file stand-in
   logic [31:0] core_mem [32];
   int          ack_lat = 0;
   int          ack_cnt = 0;
   int          req_cycles = 0;

   assign rf_rdata = core_mem[rf_idx];

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) core_mem[i] <= 32'hFFFF_FFFF ^ (i << 4);
      end else if (rf_req && rf_ack && rf_we) begin
         core_mem[rf_idx] <= rf_wdata;
      end
   end

   always @(negedge clk) begin
      if (!rf_req) begin
         ack_cnt = 0;
         rf_ack  = 1'b0;
      end else begin
         rf_ack  = (ack_cnt >= ack_lat);
         ack_cnt = ack_cnt + 1;
         req_cycles = req_cycles + 1;
      end
   end

   // behavioural reference model
   bit          m_busy, m_ready, m_we;
   int          m_idx;
   logic [31:0] m_data;

   function automatic bit is_rsvd(int idx);
      return (idx > 18) && (idx != 20);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_ready = 0; m_we = 0; m_idx = 0; m_data = '0;
      end else if (m_busy) begin
         if (is_rsvd(m_idx) || rf_ack) begin
            m_busy  = 0;
            m_ready = 1;
            if (!m_we) begin
               if (is_rsvd(m_idx))  m_data = '0;
               else if (m_idx == 20) m_data = core_mem[m_idx] & SPEC_M;
               else                  m_data = core_mem[m_idx];
            end
         end
      end else if (bus_wr && bus_addr == 2'd0 && core_halted) begin
         m_busy  = 1;
         m_ready = 0;
         m_idx   = int'(bus_wdata[4:0]);
         m_we    = bus_wdata[16];
      end else if (bus_wr && bus_addr == 2'd1) begin
         m_data = bus_wdata;
      end
   end

   task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #(CLK_P/4);
      if (rst_n) begin
         automatic bit          exp_req = m_busy && !is_rsvd(m_idx);
         automatic logic [31:0] exp_rd  = '0;
         if (bus_addr == 2'd1) exp_rd = m_data;
         if (bus_addr == 2'd2) exp_rd = {31'b0, m_ready};
         cmp({cur_req, " ready"}, 32'(xfer_ready), 32'(m_ready));
         cmp({cur_req, " req"}, 32'(rf_req), 32'(exp_req));
         cmp({cur_req, " rdata"}, bus_rdata, exp_rd);
         if (exp_req) begin
            cmp({cur_req, " idx"}, 32'(rf_idx), 32'(m_idx));
            cmp({cur_req, " dir"}, 32'(rf_we), 32'(m_we));
            if (m_we) cmp({cur_req, " wdata"}, rf_wdata, (m_idx == 20) ? (m_data & SPEC_M) : m_data);
         end
      end
   end

   task automatic bus_write(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 2'd1;
   endtask

   task automatic rd(logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic wait_done();
      int t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!(m_ready && !m_busy) && t < 50);
      if (t >= 50) cmp({cur_req, " completion timeout"}, 32'd0, 32'd1);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0; core_halted = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1 ready", 32'(xfer_ready), 32'd0);
      cmp("R1 req", 32'(rf_req), 32'd0);
      rd(2'd1, v); cmp("R1 data", v, 32'd0);

      cur_req = "R11";
      rd(2'd0, v); cmp("R11 addr0", v, 32'd0);
      rd(2'd3, v); cmp("R11 addr3", v, 32'd0);
      rd(2'd2, v); cmp("R11 status", v, 32'd0);
      cur_req = "R10";
      bus_write(2'd1, 32'hDEAD_BEEF);
      rd(2'd1, v); cmp("R10 data load", v, 32'hDEAD_BEEF);

      cur_req = "R8";
      req_cycles = 0;
      bus_write(2'd0, 32'h0000_0003);
      repeat (4) @(negedge clk);
      cmp("R8 ready", 32'(xfer_ready), 32'd0);
      cmp("R8 no req", 32'(req_cycles), 32'd0);

      core_halted = 1'b1;
      cur_req = "R2";
      ack_lat = 2; req_cycles = 0;
      bus_write(2'd0, 32'h0000_0005);
      cmp("R2 req", 32'(rf_req), 32'd1);
      cmp("R2 idx", 32'(rf_idx), 32'd5);
      cmp("R2 dir", 32'(rf_we), 32'd0);
      cmp("R2 ready low", 32'(xfer_ready), 32'd0);
      wait_done();
      cur_req = "R4";
      rd(2'd1, v); cmp("R4 read result", v, core_mem[5]);
      cmp("R3 req length", 32'(req_cycles), 32'd3);

      cur_req = "R5";
      bus_write(2'd1, 32'h1234_5678);
      ack_lat = 0;
      bus_write(2'd0, 32'h0001_0007);
      wait_done();
      @(negedge clk);
      cmp("R5 core written", core_mem[7], 32'h1234_5678);
      rd(2'd1, v); cmp("R5 data kept", v, 32'h1234_5678);

      cur_req = "R9";
      ack_lat = 4; req_cycles = 0;
      bus_write(2'd0, 32'h0000_0002);
      bus_write(2'd1, 32'h0000_FFFF);
      bus_write(2'd0, 32'h0000_0009);
      wait_done();
      rd(2'd1, v); cmp("R10 busy write dropped", v, core_mem[2]);
      cmp("R3 req length lat4", 32'(req_cycles), 32'd5);
      repeat (3) @(negedge clk);
      cmp("R9 no second transfer", 32'(req_cycles), 32'd5);

      cur_req = "R6";
      ack_lat = 1;
      bus_write(2'd0, 32'h0000_0014);
      wait_done();
      rd(2'd1, v); cmp("R6 special read", v, 32'h0300_0001);
      bus_write(2'd1, 32'hFFFF_FFFF);
      bus_write(2'd0, 32'h0001_0014);
      wait_done();
      @(negedge clk);
      cmp("R6 special write", core_mem[20], 32'h0300_0001);

      cur_req = "R7";
      req_cycles = 0;
      bus_write(2'd1, 32'hCAFE_F00D);
      bus_write(2'd0, 32'h0000_0013);
      wait_done();
      rd(2'd1, v); cmp("R7 reserved read zero", v, 32'd0);
      bus_write(2'd1, 32'h0BAD_C0DE);
      bus_write(2'd0, 32'h0001_001F);
      cmp("R7 not yet ready", 32'(xfer_ready), 32'd0);
      @(negedge clk);
      cmp("R7 ready next cycle", 32'(xfer_ready), 32'd1);
      rd(2'd1, v); cmp("R7 reserved write keeps data", v, 32'h0BAD_C0DE);
      cmp("R7 no request", 32'(req_cycles), 32'd0);

      cur_req = "R2";
      for (int k = 0; k <= 18; k++) begin
         ack_lat = k % 3;
         bus_write(2'd0, 32'(k));
         wait_done();
         rd(2'd1, v); cmp("R2 sweep read", v, core_mem[k]);
      end

      cur_req = "R8";
      core_halted = 1'b0;
      bus_write(2'd0, 32'h0000_0004);
      repeat (3) @(negedge clk);
      cmp("R8 ready kept", 32'(xfer_ready), 32'd1);
      cmp("R8 still no req", 32'(rf_req), 32'd0);

      summary();
   end

endmodule